// File: doc/BRIEF.md
# Clock Output Stop and Gating Controller

This block sits between the output dividers of a multi-output clock generator and its pad drivers. For every output it decides, on each half-cycle, whether the output toggles, is parked at a driven level, or is released to high impedance. Outputs fall into two families: a processor family, stopped by its own active-low stop pin, and a serial/peripheral family, stopped by a second active-low stop pin or by a software stop bit. Each output carries its own configuration: enable, free-running versus stoppable, Hi-Z versus driven while stopped, and Hi-Z versus driven while powered down.

Two link request pins let downstream devices release the serial outputs they do not need. Each pin owns a selection mask, and while the pin is high every selected output floats. An asynchronous power-down input overrides everything at once. Leaving power-down is synchronized, so the first pulse after wake-up is a full one.

Every output has its own source clock, and its whole control path runs on the falling edge of that clock. As a result, a state change always lands while the source clock is low, and no shortened high pulse ever reaches a pad. The true leg is the gated clock and the complement leg is always its inverse, so a differential output that is stopped in driven mode sits with its true leg low and its complement leg high.

Top module: `clk_stop_ctrl`

## Requirements
- R1: When an output's enable bit is 0, its output enable drops to 0 (Hi-Z) and its true leg stays low. When the bit is 1, the output follows the other controls. A change of the bit takes effect at the next falling edge of that output's source clock.
- R2: While the serial stop pin is low, each serial-family output whose stoppable bit is 1 holds its true leg low. Serial outputs whose stoppable bit is 0 keep toggling.
- R3: Setting the software stop bit to 1 stops the serial family exactly as a low serial stop pin would. It has no effect on processor-family outputs. It takes effect at the next falling edge.
- R4: While the processor stop pin is low, each processor-family output whose stoppable bit is 1 holds its true leg low. Free-running processor outputs and all serial outputs are unaffected.
- R5: A stopped output whose stop drive bit is 0 stays driven (output enable 1, true low, complement high). A stopped output whose stop drive bit is 1 goes Hi-Z.
- R6: Each of the two link request pins has its own mask, and bit i of a mask selects output i. While a pin is high, every output selected by its mask has output enable 0 and a low true leg. The two masks act independently of each other.
- R7: While power-down is high, every output immediately holds its true leg low and its complement leg high, with output enable equal to the inverse of its power-down drive bit (0 = driven, 1 = Hi-Z). After power-down falls, normal operation resumes at the second falling edge of the source clock.
- R8: Priority: power-down first, then a disabled output or an asserted link request, then a stop request, then running.
- R9: A pin change is registered at falling edges only and acts at the third falling edge after it. During the low phase of the source clock the true leg is always low, so no partial high pulse is produced.
- R10: While reset is low, and until the controller first updates at the third falling edge after release, every output is Hi-Z with a low true leg.
- R11: The complement leg is at all times the inverse of the true leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | N_OUT | Free-running source clock, one per output |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd | input | 1 | Asynchronous active-high power-down |
| cpu_stop_n | input | 1 | Active-low stop for the processor family |
| pci_stop_n | input | 1 | Active-low stop for the serial family |
| link_req_n | input | 2 | Link request pins; a high pin floats the outputs in its mask |
| cfg_en | input | N_OUT | Per-output enable (1 = enabled) |
| cfg_stoppable | input | N_OUT | 1 = output obeys its family's stop request |
| cfg_stop_hiz | input | N_OUT | 1 = Hi-Z while stopped, 0 = driven low |
| cfg_pd_hiz | input | N_OUT | 1 = Hi-Z in power-down, 0 = driven low |
| cfg_soft_stop | input | 1 | Software equivalent of a low serial stop pin |
| cfg_req0_sel | input | N_OUT | Outputs controlled by link request pin 0 |
| cfg_req1_sel | input | N_OUT | Outputs controlled by link request pin 1 |
| clk_t | output | N_OUT | Gated true leg |
| clk_c | output | N_OUT | Complement leg |
| oe | output | N_OUT | Pad output enable (0 = Hi-Z) |

## Verification
The bench targets the boundaries between states. It toggles stop pins at one-, two- and three-cycle spacing to test the third-falling-edge latency and low-phase-only switching. A design that updated on the rising edge, or that used one synchronizer stage too few or too many, would clip pulses or change state a cycle off. It asserts power-down on top of active link requests and stop requests, and switches the drive bits while outputs are held. A wrong priority order would leave an output driven or toggling where it should float. It also checks that the software stop leaves processor outputs running, that free-running serial outputs survive a serial stop, and that power-down exit waits two falling edges. A wake-up that is not synchronized would show up as a one-cycle-early pulse.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  // Per-output control state, held in a falling-edge register.
  typedef enum logic [1:0] {
    OM_OFF      = 2'd0,  // Hi-Z, true leg low (disabled or link released)
    OM_RUN      = 2'd1,  // clock passes
    OM_HOLD_DRV = 2'd2,  // stopped, driven low
    OM_HOLD_Z   = 2'd3   // stopped, Hi-Z
  } out_mode_e;

  // Synchronized pin vector layout: {req1_n, req0_n, pci_stop_n, cpu_stop_n}.
  localparam int unsigned PIN_W      = 4;
  localparam int unsigned PIN_CPU    = 0;
  localparam int unsigned PIN_PCI    = 1;
  localparam int unsigned PIN_REQ_LO = 2;
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0011;

endpackage

// File: rtl/cg_sync_fall.sv
module cg_sync_fall #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  // Falling-edge synchronizer chain: keeps every change inside the low phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cg_pd_hold.sv
module cg_pd_hold #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  output logic pd_act
);

  logic [STAGES-1:0] hold_q;

  // Asynchronous entry, exit released by falling edges only.
  always_ff @(negedge clk or negedge rst_n or posedge pd) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (pd) begin
      hold_q <= '1;
    end else begin
      hold_q <= {hold_q[STAGES-2:0], 1'b0};
    end
  end

  assign pd_act = hold_q[STAGES-1];

endmodule

// File: rtl/cg_out_slice.sv
module cg_out_slice
  import clkgate_pkg::*;
#(
  parameter bit          IS_CPU      = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       src_clk,
  input  logic       rst_n,
  input  logic       pd,
  input  logic       cpu_stop_n,
  input  logic       pci_stop_n,
  input  logic [1:0] req_n,
  input  logic       cfg_en,
  input  logic       cfg_stoppable,
  input  logic       cfg_stop_hiz,
  input  logic       cfg_pd_hiz,
  input  logic       cfg_soft_stop,
  input  logic [1:0] cfg_req_sel,
  output logic       clk_t,
  output logic       clk_c,
  output logic       oe
);

  logic             rst_l;
  logic [PIN_W-1:0] pins_s;
  logic             pd_act;
  out_mode_e        mode_q, mode_nxt;
  logic             mode_upd;
  logic             req_hit, stop_req, stop_hit;
  logic             run_gate;

  // Reset release aligned to this output's falling edge.
  cg_sync_fall #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(src_clk), .rst_n(rst_n), .d(1'b1), .q(rst_l)
  );

  cg_sync_fall #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_pin_sync (
    .clk(src_clk), .rst_n(rst_l),
    .d({req_n, pci_stop_n, cpu_stop_n}), .q(pins_s)
  );

  cg_pd_hold #(.STAGES(SYNC_STAGES)) u_pd_hold (
    .clk(src_clk), .rst_n(rst_l), .pd(pd), .pd_act(pd_act)
  );

  // Next state: disable/link release dominate stop, stop dominates run.
  always_comb begin
    req_hit  = |(pins_s[PIN_REQ_LO +: 2] & cfg_req_sel);
    stop_req = IS_CPU ? !pins_s[PIN_CPU] : (!pins_s[PIN_PCI] || cfg_soft_stop);
    stop_hit = cfg_stoppable && stop_req;
    if (!cfg_en || req_hit) begin
      mode_nxt = OM_OFF;
    end else if (stop_hit) begin
      mode_nxt = cfg_stop_hiz ? OM_HOLD_Z : OM_HOLD_DRV;
    end else begin
      mode_nxt = OM_RUN;
    end
    mode_upd = (mode_nxt != mode_q);
  end

  always_ff @(negedge src_clk or negedge rst_l) begin
    if (!rst_l) begin
      mode_q <= OM_OFF;
    end else if (mode_upd) begin
      mode_q <= mode_nxt;
    end
  end

  // Output stage: power-down overrides the registered state.
  always_comb begin
    run_gate = (mode_q == OM_RUN) && !pd_act;
    clk_t    = src_clk & run_gate;
    clk_c    = ~clk_t;
    if (pd_act) begin
      oe = !cfg_pd_hiz;
    end else begin
      oe = (mode_q == OM_RUN) || (mode_q == OM_HOLD_DRV);
    end
  end

  assert_disable_floats_R1: assert property (@(negedge src_clk) disable iff (!rst_l)
    !cfg_en |=> (pd_act || !oe));

  assert_free_run_toggles_R2: assert property (@(negedge src_clk) disable iff (!rst_l)
    (cfg_en && !cfg_stoppable && !req_hit && !pd) |=> (pd_act || clk_t));

  assert_stop_parks_low_R4: assert property (@(negedge src_clk) disable iff (!rst_l)
    stop_hit |=> !clk_t);

  assert_link_release_R6: assert property (@(negedge src_clk) disable iff (!rst_l)
    req_hit |=> (pd_act || !oe));

  assert_pd_overrides_R7: assert property (@(negedge src_clk) disable iff (!rst_l)
    pd |-> (!clk_t && (oe == !cfg_pd_hiz)));

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int unsigned N_OUT       = 8,
  parameter logic [N_OUT-1:0] CPU_SET = 8'h03,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic [N_OUT-1:0] src_clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic [1:0]       link_req_n,
  input  logic [N_OUT-1:0] cfg_en,
  input  logic [N_OUT-1:0] cfg_stoppable,
  input  logic [N_OUT-1:0] cfg_stop_hiz,
  input  logic [N_OUT-1:0] cfg_pd_hiz,
  input  logic             cfg_soft_stop,
  input  logic [N_OUT-1:0] cfg_req0_sel,
  input  logic [N_OUT-1:0] cfg_req1_sel,
  output logic [N_OUT-1:0] clk_t,
  output logic [N_OUT-1:0] clk_c,
  output logic [N_OUT-1:0] oe
);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    cg_out_slice #(.IS_CPU(CPU_SET[i]), .SYNC_STAGES(SYNC_STAGES)) u_slice (
      .src_clk      (src_clk[i]),
      .rst_n        (rst_n),
      .pd           (pd),
      .cpu_stop_n   (cpu_stop_n),
      .pci_stop_n   (pci_stop_n),
      .req_n        (link_req_n),
      .cfg_en       (cfg_en[i]),
      .cfg_stoppable(cfg_stoppable[i]),
      .cfg_stop_hiz (cfg_stop_hiz[i]),
      .cfg_pd_hiz   (cfg_pd_hiz[i]),
      .cfg_soft_stop(cfg_soft_stop),
      .cfg_req_sel  ({cfg_req1_sel[i], cfg_req0_sel[i]}),
      .clk_t        (clk_t[i]),
      .clk_c        (clk_c[i]),
      .oe           (oe[i])
    );
  end

endmodule

// File: tb/clk_stop_ctrl_tb.sv
module clk_stop_ctrl_tb_top;

  localparam int N = 8;
  localparam logic [N-1:0] CPU_SET = 8'h03;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, pd, cpu_stop_n, pci_stop_n, cfg_soft_stop;
  logic [1:0]   link_req_n;
  logic [N-1:0] cfg_en, cfg_stoppable, cfg_stop_hiz, cfg_pd_hiz, cfg_req0_sel, cfg_req1_sel;
  logic [N-1:0] clk_t, clk_c, oe;

  clk_stop_ctrl #(.N_OUT(N), .CPU_SET(CPU_SET), .SYNC_STAGES(2)) dut_i (
    .src_clk({N{clk}}), .rst_n(rst_n), .pd(pd), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .link_req_n(link_req_n), .cfg_en(cfg_en),
    .cfg_stoppable(cfg_stoppable), .cfg_stop_hiz(cfg_stop_hiz), .cfg_pd_hiz(cfg_pd_hiz),
    .cfg_soft_stop(cfg_soft_stop), .cfg_req0_sel(cfg_req0_sel), .cfg_req1_sel(cfg_req1_sel),
    .clk_t(clk_t), .clk_c(clk_c), .oe(oe)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_tag = "R10";

  // Reference model: 0 off, 1 run, 2 stopped driven, 3 stopped Hi-Z.
  int         mmode [N];
  logic [3:0] hist [$];
  logic       pd_h0, pd_h1;
  int         ncnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      ncnt = 0;
      foreach (mmode[i]) mmode[i] = 0;
      hist = {4'b0011, 4'b0011};
      pd_h0 = 1'b0;
      pd_h1 = 1'b0;
    end else begin
      ncnt++;
      if (ncnt >= 3) begin
        logic [3:0] use_p;
        use_p = hist.pop_front();
        for (int i = 0; i < N; i++) begin
          logic off, sreq;
          off  = !cfg_en[i] || (use_p[2] && cfg_req0_sel[i]) || (use_p[3] && cfg_req1_sel[i]);
          sreq = CPU_SET[i] ? !use_p[0] : (!use_p[1] || cfg_soft_stop);
          if (off) mmode[i] = 0;
          else if (cfg_stoppable[i] && sreq) mmode[i] = cfg_stop_hiz[i] ? 3 : 2;
          else mmode[i] = 1;
        end
        hist.push_back({link_req_n, pci_stop_n, cpu_stop_n});
      end
      pd_h1 = pd_h0;
      pd_h0 = pd;
    end
  end

  task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // High phase: full comparison against the model.
  always @(posedge clk) begin
    #2;
    begin
      logic [N-1:0] et, eo;
      logic pda;
      pda = pd | (rst_n & (pd_h0 | pd_h1));
      for (int i = 0; i < N; i++) begin
        if (pda) begin
          et[i] = 1'b0;
          eo[i] = !cfg_pd_hiz[i];
        end else begin
          et[i] = (mmode[i] == 1);
          eo[i] = (mmode[i] == 1) || (mmode[i] == 2);
        end
      end
      check(cur_tag, "clk_t", clk_t, et);
      check(cur_tag, "oe", oe, eo);
      check("R11", "clk_c", clk_c, ~clk_t);
    end
  end

  // Low phase: no output may be high (R9 runt-free switching).
  always @(negedge clk) begin
    #2;
    check("R9", "clk_t_low_phase", clk_t, '0);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; pd = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; link_req_n = 2'b00;
    cfg_en = '1; cfg_stoppable = 8'b1111_0001; cfg_stop_hiz = '0; cfg_pd_hiz = '0;
    cfg_soft_stop = 1'b0; cfg_req0_sel = 8'b0010_0000; cfg_req1_sel = 8'b0100_0000;
    #1 rst_n = 1'b0;
    cur_tag = "R10";
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(6);

    cur_tag = "R1";
    cfg_en = 8'b1111_0110; wait_cyc(6);
    cfg_en = '1;           wait_cyc(4);

    cur_tag = "R2";
    pci_stop_n = 1'b0; wait_cyc(8);
    pci_stop_n = 1'b1; wait_cyc(6);

    cur_tag = "R5";
    cfg_stop_hiz = 8'hA1; pci_stop_n = 1'b0; cpu_stop_n = 1'b0; wait_cyc(8);
    cfg_stop_hiz = 8'h50; wait_cyc(4);
    pci_stop_n = 1'b1; cpu_stop_n = 1'b1; wait_cyc(5);
    cfg_stop_hiz = '0;

    cur_tag = "R3";
    cfg_soft_stop = 1'b1; wait_cyc(6);
    cfg_soft_stop = 1'b0; wait_cyc(4);

    cur_tag = "R4";
    cpu_stop_n = 1'b0; wait_cyc(8);
    cfg_stoppable[1] = 1'b1; wait_cyc(4);
    cpu_stop_n = 1'b1; wait_cyc(6);
    cfg_stoppable[1] = 1'b0;

    cur_tag = "R6";
    link_req_n = 2'b01; wait_cyc(6);
    link_req_n = 2'b11; wait_cyc(6);
    cfg_req0_sel = 8'h0C; wait_cyc(6);
    link_req_n = 2'b10; wait_cyc(6);
    link_req_n = 2'b00; cfg_req0_sel = 8'h20; wait_cyc(6);

    cur_tag = "R7";
    pd = 1'b1; wait_cyc(5);
    cfg_pd_hiz = 8'hAA; wait_cyc(4);
    pd = 1'b0; wait_cyc(6);
    cfg_pd_hiz = '0;

    cur_tag = "R8";
    link_req_n = 2'b11; pci_stop_n = 1'b0; cpu_stop_n = 1'b0; pd = 1'b1; wait_cyc(6);
    pd = 1'b0; wait_cyc(6);
    link_req_n = 2'b00; cfg_en[4] = 1'b0; wait_cyc(6);
    cfg_en = '1; pci_stop_n = 1'b1; cpu_stop_n = 1'b1; wait_cyc(6);

    cur_tag = "R9";
    for (int k = 0; k < 12; k++) begin
      pci_stop_n = ~pci_stop_n;
      cpu_stop_n = (k % 2 == 0);
      wait_cyc(1 + k % 3);
    end
    pci_stop_n = 1'b1; cpu_stop_n = 1'b1; wait_cyc(6);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule